// File: doc/BRIEF.md
# Misaligned Segment Descriptor Splitter

This block turns a stream of scatter-gather segments into the 64-bit descriptor entries that a DMA engine restricted to word-aligned addresses can walk. Each segment arrives as a 32-bit byte address and a byte length over a valid/ready handshake, with a flag marking the final segment of a list. A segment that starts on a word boundary becomes one transfer entry. A segment that does not is split. First comes a short entry of one to three bytes, which points at the next free 4-byte slot of a bounce region. Then comes an entry for the word-aligned rest of the segment. After the final segment the block appends an end-of-table entry.

Software, or a sequencer, pulses `start` with the bounce region base before each list. The descriptors leave through a registered valid/ready port, so a table writer or a descriptor FIFO can apply backpressure. Moving bytes into or out of the bounce slots is handled elsewhere. Bad input puts the block into a sticky error state that only reset clears: a zero or oversized length, more segments than a list may hold, or a misaligned bounce base.

Top module: `sgdesc_split`

## Requirements
- R1: Every descriptor is laid out with the address in bits 63:32, the length in bits 31:16 and the attribute in bits 15:0. The length field holds the low 16 bits of the byte count, so 65536 is written as 0. Transfer entries carry attribute 0x0021.
- R2: For a segment whose address has nonzero low two bits `a`, the block first emits a head entry. Its length is the smaller of `4 - a` and the segment length. Its address is the bounce base plus 4 times the number of head entries already emitted since the last start.
- R3: After the head entry, the body entry carries the segment address raised by the head length and the segment length lowered by it. A word-aligned segment yields a single entry with its own address and length.
- R4: When the head length equals the segment length, no body entry is emitted.
- R5: After the entries of a segment flagged last, the block emits one end entry: address 0, length 0, attribute 0x0003. It then emits nothing further and holds `seg_ready` low until the next start.
- R6: A start pulse loads the bounce base and clears the slot and segment counts. `seg_ready` is high in the cycle after the start edge.
- R7: While `desc_valid` is high and `desc_ready` is low, `desc_valid` and `desc_data` stay unchanged. No entry is lost or repeated under backpressure.
- R8: An accepted segment with length 0 or above 65536 sets `err`. `err` then stays high, with `seg_ready` and `desc_valid` low, until reset. A start pulse does not clear it.
- R9: An accepted 129th segment within one list sets the error state of R8.
- R10: A start pulse whose bounce base has nonzero low two bits sets the error state of R8.
- R11: After reset, `seg_ready`, `desc_valid` and `err` are low until a start pulse.
- R12: No list produces more than 257 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new list, loads the bounce base |
| bounce_base | input | 32 | Byte address of the bounce region, word aligned |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high with seg_valid |
| seg_addr | input | 32 | Segment start byte address |
| seg_len | input | 17 | Segment length in bytes, 1 to 65536 |
| seg_last | input | 1 | Segment is the final one of the list |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Consumer takes the descriptor |
| desc_data | output | 64 | Descriptor entry |
| err | output | 1 | Sticky error state |

## Verification
The bench targets these corner cases:
- Segments at each of the four address phases. A wrong head formula would misplace the body address by a byte or two.
- A head that covers the whole segment. A design that ignored this case would emit a zero-length body.
- A segment shorter than its head gap. A design that missed this case would emit a head longer than the data.
- The 65536-byte length. It must wrap to 0 in the field and not be flagged as an error.
- A second list with a new base. A slot pointer that is not cleared would keep counting from the old list.
- A consumer that stalls at irregular times. A faulty output stage would drop or repeat entries.
- The error cases: the 129th segment, an oversized or zero length, and an unaligned base. A design without a sticky error would keep producing entries, or would be cleared by the next start.

// File: rtl/sgdesc_pkg.sv
`timescale 1ns/1ps
package sgdesc_pkg;
  localparam int ATTR_W = 16;
  localparam logic [ATTR_W-1:0] ATTR_XFER = 16'h0021;
  localparam logic [ATTR_W-1:0] ATTR_END  = 16'h0003;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEG, ST_HEAD, ST_BODY, ST_TERM, ST_DONE, ST_ERR
  } sg_state_t;
endpackage

// File: rtl/sgdesc_split_calc.sv
`timescale 1ns/1ps
module sgdesc_split_calc #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 17,
  parameter int MAX_LEN = 65536
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic [1:0]        head_len,
  output logic [ADDR_W-1:0] body_addr,
  output logic [LEN_W-1:0]  body_len,
  output logic              len_bad
);
  logic [1:0] gap;

  always_comb begin
    gap       = 2'(3'd4 - {1'b0, addr[1:0]});
    head_len  = (len < LEN_W'(gap)) ? len[1:0] : gap;
    body_addr = addr + ADDR_W'(head_len);
    body_len  = len - LEN_W'(head_len);
    len_bad   = (len == '0) || (len > LEN_W'(MAX_LEN));
  end
endmodule

// File: rtl/sgdesc_ctrl.sv
`timescale 1ns/1ps
module sgdesc_ctrl
  import sgdesc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 17,
  parameter int DLEN_W   = 16,
  parameter int MAX_SEGS = 128
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [ADDR_W-1:0]             bounce_base,
  input  logic                          seg_valid,
  output logic                          seg_ready,
  input  logic                          seg_last,
  input  logic [1:0]                    c_head_len,
  input  logic [ADDR_W-1:0]             c_body_addr,
  input  logic [LEN_W-1:0]              c_body_len,
  input  logic                          c_len_bad,
  output logic                          desc_valid,
  input  logic                          desc_ready,
  output logic [ADDR_W+DLEN_W+ATTR_W-1:0] desc_data,
  output logic                          err
);
  localparam int DESC_W      = ADDR_W + DLEN_W + ATTR_W;
  localparam int MAX_ENTRIES = 2 * MAX_SEGS + 1;
  localparam int SEG_W       = $clog2(MAX_SEGS + 1);
  localparam int ENT_W       = $clog2(MAX_ENTRIES + 1);

  sg_state_t            st;
  logic [ADDR_W-1:0]    slot_q, body_addr_q;
  logic [LEN_W-1:0]     body_len_q;
  logic [1:0]           head_q;
  logic                 last_q;
  logic [SEG_W-1:0]     seg_cnt;
  logic [ENT_W-1:0]     ent_cnt;
  logic                 valid_q;
  logic [DESC_W-1:0]    data_q;

  logic out_free, accept, seg_bad, has_body;

  assign out_free  = !valid_q || desc_ready;
  assign seg_ready = (st == ST_SEG);
  assign accept    = seg_valid && seg_ready;
  assign seg_bad   = c_len_bad || (seg_cnt == SEG_W'(MAX_SEGS));
  assign has_body  = (body_len_q != '0);
  assign desc_valid = valid_q;
  assign desc_data  = data_q;
  assign err        = (st == ST_ERR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      valid_q     <= 1'b0;
      data_q      <= '0;
      slot_q      <= '0;
      body_addr_q <= '0;
      body_len_q  <= '0;
      head_q      <= '0;
      last_q      <= 1'b0;
      seg_cnt     <= '0;
      ent_cnt     <= '0;
    end else if (st != ST_ERR) begin
      if (out_free) valid_q <= 1'b0;
      if (start) begin
        valid_q <= 1'b0;
        if (bounce_base[1:0] != 2'b00) begin
          st <= ST_ERR;
        end else begin
          slot_q  <= bounce_base;
          seg_cnt <= '0;
          ent_cnt <= '0;
          st      <= ST_SEG;
        end
      end else begin
        case (st)
          ST_SEG: if (accept) begin
            if (seg_bad) begin
              st      <= ST_ERR;
              valid_q <= 1'b0;
            end else begin
              head_q      <= c_head_len;
              body_addr_q <= c_body_addr;
              body_len_q  <= c_body_len;
              last_q      <= seg_last;
              seg_cnt     <= seg_cnt + 1'b1;
              st          <= (c_head_len != 2'd0) ? ST_HEAD : ST_BODY;
            end
          end
          ST_HEAD: if (out_free) begin
            data_q  <= {slot_q, DLEN_W'(head_q), ATTR_XFER};
            valid_q <= 1'b1;
            slot_q  <= slot_q + ADDR_W'(4);
            ent_cnt <= ent_cnt + 1'b1;
            st      <= has_body ? ST_BODY : (last_q ? ST_TERM : ST_SEG);
          end
          ST_BODY: if (out_free) begin
            data_q  <= {body_addr_q, DLEN_W'(body_len_q), ATTR_XFER};
            valid_q <= 1'b1;
            ent_cnt <= ent_cnt + 1'b1;
            st      <= last_q ? ST_TERM : ST_SEG;
          end
          ST_TERM: if (out_free) begin
            data_q  <= {ADDR_W'(0), DLEN_W'(0), ATTR_END};
            valid_q <= 1'b1;
            ent_cnt <= ent_cnt + 1'b1;
            st      <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  // R7: a stalled entry is held until taken
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !desc_ready && !start && !accept)
    |=> (valid_q && $stable(data_q)));

  // R8: the error state is sticky and silent
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    err |-> (!seg_ready && !valid_q));

  // R2: a head entry covers one to three bytes of a word-aligned slot
  p_head_shape_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HEAD && out_free && !start)
    |=> (valid_q && data_q[DLEN_W+ATTR_W-1:ATTR_W] != '0
         && data_q[DLEN_W+ATTR_W-1:ATTR_W] < DLEN_W'(4)
         && data_q[ATTR_W+DLEN_W+1:ATTR_W+DLEN_W] == 2'b00));

  // R12: entry count per list is bounded
  p_entry_bound_r12: assert property (@(posedge clk) disable iff (rst)
    ent_cnt <= ENT_W'(MAX_ENTRIES));

  // R5: nothing is offered for input once the list is closed
  p_done_closed_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE) |-> !seg_ready);
endmodule

// File: rtl/sgdesc_split.sv
`timescale 1ns/1ps
module sgdesc_split #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 17,
  parameter int DLEN_W   = 16,
  parameter int MAX_LEN  = 65536,
  parameter int MAX_SEGS = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] bounce_base,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [ADDR_W-1:0] seg_addr,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic              seg_last,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [63:0]       desc_data,
  output logic              err
);
  logic [1:0]        head_len;
  logic [ADDR_W-1:0] body_addr;
  logic [LEN_W-1:0]  body_len;
  logic              len_bad;

  sgdesc_split_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_calc (
    .addr(seg_addr), .len(seg_len), .head_len(head_len),
    .body_addr(body_addr), .body_len(body_len), .len_bad(len_bad)
  );

  sgdesc_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DLEN_W(DLEN_W), .MAX_SEGS(MAX_SEGS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .bounce_base(bounce_base),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_last(seg_last),
    .c_head_len(head_len), .c_body_addr(body_addr), .c_body_len(body_len),
    .c_len_bad(len_bad), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_data(desc_data), .err(err)
  );
endmodule

// File: tb/sgdesc_split_bench.sv
`timescale 1ns/1ps
module sgdesc_split_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] bounce_base = '0;
  logic        seg_valid = 1'b0;
  logic        seg_ready;
  logic [31:0] seg_addr = '0;
  logic [16:0] seg_len = '0;
  logic        seg_last = 1'b0;
  logic        desc_valid;
  logic        desc_ready;
  logic [63:0] desc_data;
  logic        err;

  always #2.5 clk = ~clk;

  sgdesc_split u_sgdesc_split (
    .clk(clk), .rst(rst), .start(start), .bounce_base(bounce_base),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_data(desc_data), .err(err)
  );

  // {last, len[16:0], addr[31:0]}
  localparam int NV = 7;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 17'd512,   32'h1000_0000},
    {1'b0, 17'd100,   32'h2000_0001},
    {1'b0, 17'd2,     32'h2000_0102},
    {1'b0, 17'd65536, 32'h3000_0003},
    {1'b0, 17'd65536, 32'h4000_0000},
    {1'b0, 17'd1,     32'h5000_0002},
    {1'b1, 17'd9,     32'h6000_0007}
  };

  int total = 0, failed = 0, cyc = 0;
  logic [63:0] cap [300];
  int cap_n = 0;
  logic [63:0] expv [32];
  string exptag [32];
  int exp_n;
  logic bp_mode = 1'b0;
  int hold_bad = 0;
  logic pv = 1'b0, pr = 1'b0;
  logic [63:0] pd = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 desc_ready = bp_mode ? (cyc[0] ^ cyc[2] ^ cyc[3]) : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst && pv && !pr && (!desc_valid || desc_data != pd)) hold_bad++;
    pv = desc_valid; pr = desc_ready; pd = desc_data;
    if (desc_valid && desc_ready) begin
      if (cap_n < 300) cap[cap_n] = desc_data;
      cap_n++;
    end
  end

  always @(posedge clk) begin
    if (cyc == 100000) begin
      total++; failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] expd);
    total++;
    if (act !== expd) begin
      failed++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expd);
    end
  endtask

  task automatic push(input logic [63:0] d, input string tag);
    expv[exp_n] = d; exptag[exp_n] = tag; exp_n++;
  endtask

  task automatic build_exp(input logic [31:0] base);
    logic [31:0] slot = base;
    exp_n = 0;
    for (int i = 0; i < NV; i++) begin
      logic [31:0] a = VEC[i][31:0];
      int l = int'(VEC[i][48:32]);
      int gap = (4 - int'(a[1:0])) % 4;
      int h = (l < gap) ? l : gap;
      int bl = l - h;
      if (h > 0) begin
        push({slot, 16'(h), 16'h0021}, "R2");
        slot = slot + 4;
      end
      if (bl > 0) push({a + 32'(h), 16'(bl), 16'h0021}, (h > 0) ? "R3" : "R1");
      if (VEC[i][49]) push({32'h0, 16'h0, 16'h0003}, "R5");
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1; start = 1'b0; seg_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic do_start(input logic [31:0] base);
    @(posedge clk); #1 start = 1'b1; bounce_base = base;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic send_seg(input logic [31:0] a, input logic [16:0] l, input logic last);
    @(posedge clk); #1 seg_valid = 1'b1; seg_addr = a; seg_len = l; seg_last = last;
    @(negedge clk);
    while (!seg_ready) @(negedge clk);
    @(posedge clk); #1 seg_valid = 1'b0;
  endtask

  task automatic run_table(input logic [31:0] base, input string req_slot);
    build_exp(base);
    cap_n = 0;
    do_start(base);
    for (int i = 0; i < NV; i++) send_seg(VEC[i][31:0], VEC[i][48:32], VEC[i][49]);
    repeat (60) @(posedge clk);
    @(negedge clk);
    check("R4", "entry count", 64'(cap_n), 64'(exp_n));
    for (int i = 0; i < exp_n; i++)
      check({exptag[i], "/", req_slot}, $sformatf("entry %0d", i), cap[i], expv[i]);
    check("R5", "seg_ready low after end entry", 64'(seg_ready), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11: quiet after reset
    check("R11", "seg_ready", 64'(seg_ready), 64'd0);
    check("R11", "desc_valid", 64'(desc_valid), 64'd0);
    check("R11", "err", 64'(err), 64'd0);

    // R6: ready one cycle after start
    @(posedge clk); #1 start = 1'b1; bounce_base = 32'h8000_0100;
    @(negedge clk);
    check("R6", "seg_ready before start edge", 64'(seg_ready), 64'd0);
    @(negedge clk);
    check("R6", "seg_ready after start edge", 64'(seg_ready), 64'd1);
    #1 start = 1'b0;

    // Table walk, full-rate consumer
    run_table(32'h8000_0100, "R1");
    // Second list, new base, irregular backpressure: slots restart (R6), hold (R7)
    bp_mode = 1'b1;
    hold_bad = 0;
    run_table(32'h9000_0040, "R6");
    check("R7", "stalled entry changed", 64'(hold_bad), 64'd0);
    bp_mode = 1'b0;

    // R9: 129th segment in a list
    do_reset();
    cap_n = 0;
    do_start(32'h0000_1000);
    for (int i = 0; i < 128; i++) send_seg(32'h0001_0000 + 32'(i * 8), 17'd8, 1'b0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9", "128 segments accepted without error", 64'(err), 64'd0);
    check("R9", "entries of 128 aligned segments", 64'(cap_n), 64'd128);
    send_seg(32'h0002_0000, 17'd8, 1'b1);
    @(negedge clk);
    check("R9", "err after 129th", 64'(err), 64'd1);
    check("R9", "seg_ready in error", 64'(seg_ready), 64'd0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R9", "no entry from 129th", 64'(cap_n), 64'd128);

    // R8: oversized length, sticky across start
    do_reset();
    cap_n = 0;
    do_start(32'h0000_2000);
    send_seg(32'h0300_0001, 17'd65537, 1'b1);
    @(negedge clk);
    check("R8", "err on length 65537", 64'(err), 64'd1);
    do_start(32'h0000_2000);
    @(negedge clk);
    check("R8", "err survives start", 64'(err), 64'd1);
    check("R8", "seg_ready stays low", 64'(seg_ready), 64'd0);
    check("R8", "desc_valid stays low", 64'(desc_valid), 64'd0);
    check("R8", "no entries emitted", 64'(cap_n), 64'd0);

    // R8: zero length
    do_reset();
    do_start(32'h0000_2000);
    send_seg(32'h0300_0000, 17'd0, 1'b1);
    @(negedge clk);
    check("R8", "err on length 0", 64'(err), 64'd1);

    // R10: misaligned bounce base
    do_reset();
    @(negedge clk);
    check("R11", "err cleared by reset", 64'(err), 64'd0);
    do_start(32'h0000_3002);
    @(negedge clk);
    check("R10", "err on misaligned base", 64'(err), 64'd1);
    check("R10", "seg_ready low", 64'(seg_ready), 64'd0);

    // R12 is covered by the entry-count property; R1 entries above
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule